// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address, or into a fault code. It reads a packed 64-bit mode word that describes the processor state. The word holds the hypervisor flag, the reset-mode flag, the privileged flag, the 32-bit address mask, the fetch MMU enable, the partition number, the trap level and the primary context. Under hypervisor or reset mode no translation is done. In every other mode the block checks alignment and the unimplemented address hole, then issues one lookup on an attached TLB port and builds the physical address from the page returned. Faults update a fault status register. TLB misses update a tag access register.

The block keeps one cached translation. The cache key is the whole mode word together with the page of the last good translation. A later fetch that falls in that page under an identical mode word is answered without a TLB lookup. A pulse on `tlb_change`, raised whenever the TLB array is written or demapped, discards the cached translation.

A controller with three states handles one request at a time. In IDLE it accepts the request. It goes to RESP when the result is known at once (bypass, misalignment, hole fault or cache hit), and to WAIT when a TLB lookup is needed. WAIT holds the lookup request until the TLB answers, then goes to RESP. RESP presents the result for one cycle and returns to IDLE.

Top module: `ifx_xlate_unit`

## Requirements
- R1: The mode word is decoded as follows: bit 0 hypervisor, bit 1 reset mode, bit 2 privileged, bit 3 address mask, bit 4 MMU enable, bits 15:8 partition, bits 18:16 trap level, bits 47:32 primary context. A nonzero trap level selects nucleus context (context 0, context type 2, space ID 0x04). A zero trap level selects the primary context (context type 0, space ID 0x80).
- R2: When the hypervisor or reset-mode bit is set, the block answers with no fault and no TLB lookup. The physical address is the low 40 bits of the virtual address, even if the address is misaligned.
- R3: In any other mode, a fetch address with bit 0 or bit 1 set gives fault code 1 (misaligned), and the fault status is written with fault type 0x010.
- R4: With the address-mask bit set, bits 63:32 of the address are cleared before the lookup, and the hole check is skipped.
- R5: With the address-mask bit clear, an address from 0x0000_8000_0000_0000 to 0xFFFF_7FFF_FFFF_FFFF inclusive gives fault code 2 (access exception), with fault type 0x040.
- R6: With the MMU-enable bit clear, the lookup is marked real and uses context 0, and a miss gives fault code 3. With the bit set, a miss gives fault code 4.
- R7: On a TLB miss, and only then, the tag access register takes address bits 63:13 above the low 13 bits of the context in use.
- R8: A hit on a page marked privileged while the privileged bit is clear gives fault code 2 with fault type 0x001. The same hit with the privileged bit set translates normally.
- R9: On a hit, the physical address takes the page base outside the TLB's offset mask and the virtual address bits inside it.
- R10: Each fault status write sets bit 0, copies the old bit 0 into bit 1, and clears bits 2 and 6. It places the context type at bits 5:4, the fault type at bits 15:7 and the space ID at bits 23:16.
- R11: A fetch in the cached page under an identical mode word is answered from the cache with no TLB lookup. Any change in the mode word forces a lookup.
- R12: A `tlb_change` pulse invalidates the cached translation, so the next fetch looks up the TLB again.
- R13: After reset, `req_ready` is high, `resp_valid` is low, and both registers read zero. Each accepted request gives exactly one single-cycle `resp_valid` pulse, and `req_ready` stays low until that pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| req_valid | input | 1 | Fetch translation request |
| req_ready | output | 1 | High in IDLE, when a request can be taken |
| req_vaddr | input | 64 | Fetch virtual address |
| mode_word | input | 64 | Packed processor mode word |
| tlb_req_valid | output | 1 | TLB lookup request, held in WAIT |
| tlb_req_vaddr | output | 64 | Effective address looked up |
| tlb_req_part | output | 8 | Partition number looked up |
| tlb_req_ctx | output | 16 | Context looked up |
| tlb_req_real | output | 1 | Lookup is a real translation |
| tlb_rsp_valid | input | 1 | TLB answer strobe |
| tlb_rsp_hit | input | 1 | TLB found a matching entry |
| tlb_rsp_pbase | input | 40 | Physical page base of the entry |
| tlb_rsp_pmask | input | 40 | Page offset mask of the entry |
| tlb_rsp_priv | input | 1 | Entry is a privileged page |
| tlb_change | input | 1 | TLB array was written or demapped |
| resp_valid | output | 1 | Result strobe, one cycle in RESP |
| resp_fault_code | output | 3 | 0 none, 1 misaligned, 2 access exception, 3 real miss, 4 fast miss |
| resp_paddr | output | 40 | Physical address, meaningful when the fault code is 0 |
| fsr | output | 64 | Fault status register |
| tag_access | output | 64 | Tag access register |

## Verification
The properties assume that the TLB raises `tlb_rsp_valid` only while `tlb_req_valid` is high, for a single cycle per lookup. They also assume that `req_valid` is treated as a request only while `req_ready` is high. The bench TLB model follows this. It answers one cycle after it sees a lookup and then drops its strobe. The driver presents a new request only when the design is ready and the previous result has been retired. Every input changes on the falling clock edge, so the mode word and the address are steady at the edge where IDLE takes them.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

    typedef enum logic [2:0] {
        XF_NONE      = 3'd0,
        XF_MISALIGN  = 3'd1,
        XF_ACCESS    = 3'd2,
        XF_REAL_MISS = 3'd3,
        XF_FAST_MISS = 3'd4
    } xfault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } xstate_e;

    typedef struct packed {
        logic        hyp;
        logic        rst_mode;
        logic        priv;
        logic        amask;
        logic        mmu_en;
        logic [7:0]  part;
        logic [2:0]  tl;
        logic [15:0] pctx;
    } mode_t;

    localparam logic [8:0] FT_PRIV  = 9'h001;
    localparam logic [8:0] FT_OTHER = 9'h010;
    localparam logic [8:0] FT_RANGE = 9'h040;
    localparam logic [7:0] SPC_PRIM = 8'h80;
    localparam logic [7:0] SPC_NUC  = 8'h04;
    localparam logic [1:0] CT_PRIM  = 2'd0;
    localparam logic [1:0] CT_NUC   = 2'd2;

    function automatic mode_t decode_mode(input logic [63:0] w);
        mode_t m;
        m.hyp      = w[0];
        m.rst_mode = w[1];
        m.priv     = w[2];
        m.amask    = w[3];
        m.mmu_en   = w[4];
        m.part     = w[15:8];
        m.tl       = w[18:16];
        m.pctx     = w[47:32];
        return m;
    endfunction

endpackage

// File: rtl/ifx_last_xlate.sv
module ifx_last_xlate #(
    parameter int VA_W   = 64,
    parameter int PA_W   = 40,
    parameter int MODE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv,
    input  logic              fill,
    input  logic              fill_has,
    input  logic [MODE_W-1:0] fill_mode,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pbase,
    input  logic [PA_W-1:0]   fill_pmask,
    input  logic [MODE_W-1:0] look_mode,
    input  logic [VA_W-1:0]   look_va,
    output logic              hit,
    output logic [PA_W-1:0]   hit_pa
);
    localparam int HI_W = VA_W - PA_W;

    logic              c_vld, c_has;
    logic [MODE_W-1:0] c_mode;
    logic [VA_W-1:0]   c_va;
    logic [PA_W-1:0]   c_pbase, c_pmask;
    logic [VA_W-1:0]   ext_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_vld   <= 1'b0;
            c_has   <= 1'b0;
            c_mode  <= '0;
            c_va    <= '0;
            c_pbase <= '0;
            c_pmask <= '0;
        end else if (inv) begin
            c_vld <= 1'b0;
        end else if (fill) begin
            c_vld   <= 1'b1;
            c_has   <= fill_has;
            c_mode  <= fill_mode;
            c_va    <= fill_va;
            c_pbase <= fill_pbase;
            c_pmask <= fill_pmask;
        end
    end

    always_comb begin
        ext_mask = {{HI_W{1'b0}}, c_pmask};
        hit      = c_vld && c_has && (c_mode == look_mode) &&
                   (((look_va ^ c_va) & ~ext_mask) == '0);
        hit_pa   = (c_pbase & ~c_pmask) | (look_va[PA_W-1:0] & c_pmask);
    end
endmodule

// File: rtl/ifx_fault_regs.sv
module ifx_fault_regs #(
    parameter int VA_W    = 64,
    parameter int PG_BITS = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fsr_we,
    input  logic [1:0]              fsr_ct,
    input  logic [8:0]              fsr_ft,
    input  logic [7:0]              fsr_spc,
    input  logic                    tag_we,
    input  logic [VA_W-1:PG_BITS]   tag_page,
    input  logic [PG_BITS-1:0]      tag_ctx,
    output logic [63:0]             fsr_q,
    output logic [VA_W-1:0]         tag_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsr_q <= '0;
            tag_q <= '0;
        end else begin
            if (fsr_we)
                fsr_q <= {40'b0, fsr_spc, fsr_ft, 1'b0, fsr_ct, 1'b0, 1'b0, fsr_q[0], 1'b1};
            if (tag_we)
                tag_q <= {tag_page, tag_ctx};
        end
    end
endmodule

// File: rtl/ifx_xlate_unit.sv
module ifx_xlate_unit
    import ifx_pkg::*;
#(
    parameter int          VA_W    = 64,
    parameter int          PA_W    = 40,
    parameter int          MODE_W  = 64,
    parameter int          PG_BITS = 13,
    parameter logic [63:0] HOLE_LO = 64'h0000_8000_0000_0000,
    parameter logic [63:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [MODE_W-1:0] mode_word,
    output logic              tlb_req_valid,
    output logic [VA_W-1:0]   tlb_req_vaddr,
    output logic [7:0]        tlb_req_part,
    output logic [15:0]       tlb_req_ctx,
    output logic              tlb_req_real,
    input  logic              tlb_rsp_valid,
    input  logic              tlb_rsp_hit,
    input  logic [PA_W-1:0]   tlb_rsp_pbase,
    input  logic [PA_W-1:0]   tlb_rsp_pmask,
    input  logic              tlb_rsp_priv,
    input  logic              tlb_change,
    output logic              resp_valid,
    output logic [2:0]        resp_fault_code,
    output logic [PA_W-1:0]   resp_paddr,
    output logic [63:0]       fsr,
    output logic [VA_W-1:0]   tag_access
);
    localparam int AM_W = 32;

    xstate_e           st, nxt;
    mode_t             md;
    logic [VA_W-1:0]   eva;
    logic              bypass, misal, in_hole, nuc, chit, take, rsp_take, priv_viol;
    logic [15:0]       lk_ctx;
    logic [PA_W-1:0]   chit_pa, hit_pa;
    logic              fsr_we, tag_we, fill;
    logic [8:0]        fsr_ft;
    xfault_e           imm_code;
    logic [PA_W-1:0]   imm_pa;

    // State captured when a lookup is issued
    logic [MODE_W-1:0] l_mode;
    logic [VA_W-1:0]   l_va;
    logic [15:0]       l_ctx;
    logic [7:0]        l_part;
    logic              l_real, l_priv, l_nuc;
    xfault_e           r_code;
    logic [PA_W-1:0]   r_pa;

    always_comb begin
        md      = decode_mode(mode_word);
        eva     = md.amask ? {{(VA_W-AM_W){1'b0}}, req_vaddr[AM_W-1:0]} : req_vaddr;
        bypass  = md.hyp || md.rst_mode;
        misal   = req_vaddr[1:0] != 2'b00;
        in_hole = !md.amask && (req_vaddr >= HOLE_LO) && (req_vaddr <= HOLE_HI);
        nuc     = md.tl != 3'd0;
        lk_ctx  = (nuc || !md.mmu_en) ? 16'd0 : md.pctx;
    end

    ifx_last_xlate #(.VA_W(VA_W), .PA_W(PA_W), .MODE_W(MODE_W)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .inv        (tlb_change),
        .fill       (fill),
        .fill_has   (rsp_take),
        .fill_mode  (take ? mode_word : l_mode),
        .fill_va    (take ? req_vaddr : l_va),
        .fill_pbase (take ? '0 : tlb_rsp_pbase),
        .fill_pmask (take ? '0 : tlb_rsp_pmask),
        .look_mode  (mode_word),
        .look_va    (eva),
        .hit        (chit),
        .hit_pa     (chit_pa)
    );

    ifx_fault_regs #(.VA_W(VA_W), .PG_BITS(PG_BITS)) u_fregs (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsr_we   (fsr_we),
        .fsr_ct   (take ? (nuc ? CT_NUC : CT_PRIM) : (l_nuc ? CT_NUC : CT_PRIM)),
        .fsr_ft   (fsr_ft),
        .fsr_spc  (take ? (nuc ? SPC_NUC : SPC_PRIM) : (l_nuc ? SPC_NUC : SPC_PRIM)),
        .tag_we   (tag_we),
        .tag_page (l_va[VA_W-1:PG_BITS]),
        .tag_ctx  (l_ctx[PG_BITS-1:0]),
        .fsr_q    (fsr),
        .tag_q    (tag_access)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next state and outputs
    always_comb begin
        nxt           = st;
        req_ready     = 1'b0;
        tlb_req_valid = 1'b0;
        resp_valid    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid)
                    nxt = (bypass || misal || in_hole || chit) ? ST_RESP : ST_WAIT;
            end
            ST_WAIT: begin
                tlb_req_valid = 1'b1;
                if (tlb_rsp_valid) nxt = ST_RESP;
            end
            ST_RESP: begin
                resp_valid = 1'b1;
                nxt        = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        take      = (st == ST_IDLE) && req_valid;
        rsp_take  = (st == ST_WAIT) && tlb_rsp_valid;
        priv_viol = tlb_rsp_hit && tlb_rsp_priv && !l_priv;
        hit_pa    = (tlb_rsp_pbase & ~tlb_rsp_pmask) | (l_va[PA_W-1:0] & tlb_rsp_pmask);
        fill      = (take && bypass) || (rsp_take && tlb_rsp_hit && !priv_viol);
        tag_we    = rsp_take && !tlb_rsp_hit;
        fsr_we    = (take && !bypass && (misal || in_hole)) || (rsp_take && priv_viol);
        fsr_ft    = take ? (misal ? FT_OTHER : FT_RANGE) : FT_PRIV;
        imm_pa    = '0;
        if (bypass)       begin imm_code = XF_NONE;     imm_pa = req_vaddr[PA_W-1:0]; end
        else if (misal)   imm_code = XF_MISALIGN;
        else if (in_hole) imm_code = XF_ACCESS;
        else              begin imm_code = XF_NONE;     imm_pa = chit_pa; end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_mode <= '0; l_va <= '0; l_ctx <= '0; l_part <= '0;
            l_real <= 1'b0; l_priv <= 1'b0; l_nuc <= 1'b0;
            r_code <= XF_NONE; r_pa <= '0;
        end else if (take) begin
            l_mode <= mode_word; l_va <= eva; l_ctx <= lk_ctx; l_part <= md.part;
            l_real <= !md.mmu_en; l_priv <= md.priv; l_nuc <= nuc;
            r_code <= imm_code; r_pa <= imm_pa;
        end else if (rsp_take) begin
            if (!tlb_rsp_hit)   r_code <= l_real ? XF_REAL_MISS : XF_FAST_MISS;
            else if (priv_viol) r_code <= XF_ACCESS;
            else                r_code <= XF_NONE;
            r_pa <= hit_pa;
        end
    end

    assign tlb_req_vaddr   = l_va;
    assign tlb_req_part    = l_part;
    assign tlb_req_ctx     = l_ctx;
    assign tlb_req_real    = l_real;
    assign resp_fault_code = r_code;
    assign resp_paddr      = r_pa;
endmodule

// File: rtl/ifx_xlate_chk.sv
module ifx_xlate_chk #(
    parameter int VA_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic [63:0]     mode_word,
    input logic            tlb_req_valid,
    input logic            tlb_req_real,
    input logic [15:0]     tlb_req_ctx,
    input logic            resp_valid,
    input logic [2:0]      resp_fault_code,
    input logic [63:0]     fsr,
    input logic [VA_W-1:0] tag_access
);
    AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (mode_word[0] || mode_word[1]) |=> resp_valid && resp_fault_code == 3'd0); // R2
    AST_MISALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !(mode_word[0] || mode_word[1]) && req_vaddr[1:0] != 2'b00
        |=> resp_valid && resp_fault_code == 3'd1); // R3
    AST_REAL_CTX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_valid && tlb_req_real |-> tlb_req_ctx == 16'd0); // R6
    AST_TAG_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tag_access) |-> resp_valid && (resp_fault_code == 3'd3 || resp_fault_code == 3'd4)); // R7
    AST_FSR_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsr) |-> fsr[0]); // R10
    AST_FSR_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fsr) && $past(fsr[0]) |-> fsr[1]); // R10
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid && req_ready); // R13
endmodule

bind ifx_xlate_unit ifx_xlate_chk #(.VA_W(VA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_vaddr       (req_vaddr),
    .mode_word       (mode_word),
    .tlb_req_valid   (tlb_req_valid),
    .tlb_req_real    (tlb_req_real),
    .tlb_req_ctx     (tlb_req_ctx),
    .resp_valid      (resp_valid),
    .resp_fault_code (resp_fault_code),
    .fsr             (fsr),
    .tag_access      (tag_access)
);

// File: tb/tb_ifx_xlate_unit.sv
`timescale 1ns/1ps
module tb_ifx_xlate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [63:0] mode_word = '0;
    logic        tlb_req_valid, tlb_req_real;
    logic [63:0] tlb_req_vaddr;
    logic [7:0]  tlb_req_part;
    logic [15:0] tlb_req_ctx;
    logic        tlb_rsp_valid = 1'b0, tlb_rsp_hit = 1'b0, tlb_rsp_priv = 1'b0;
    logic [39:0] tlb_rsp_pbase = '0, tlb_rsp_pmask = '0;
    logic        tlb_change = 1'b0;
    logic        resp_valid;
    logic [2:0]  resp_fault_code;
    logic [39:0] resp_paddr;
    logic [63:0] fsr, tag_access;

    always #2.5 clk = ~clk;

    ifx_xlate_unit dut (.*);

    int nchk = 0, nfail = 0, lkups = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // TLB model
    logic [63:0] e_va [4];
    logic [15:0] e_ctx[4];
    logic        e_real[4], e_priv[4];
    logic [39:0] e_pb[4], e_pm[4];

    always @(negedge clk) begin
        if (tlb_rsp_valid) tlb_rsp_valid = 1'b0;
        else if (rst_n && tlb_req_valid) begin
            tlb_rsp_hit = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (!tlb_rsp_hit && (((tlb_req_vaddr ^ e_va[i]) & ~{24'b0, e_pm[i]}) == 64'd0) &&
                    tlb_req_ctx == e_ctx[i] && tlb_req_real == e_real[i] && tlb_req_part == 8'd5) begin
                    tlb_rsp_hit = 1'b1; tlb_rsp_pbase = e_pb[i];
                    tlb_rsp_pmask = e_pm[i]; tlb_rsp_priv = e_priv[i];
                end
            end
            tlb_rsp_valid = 1'b1;
            lkups++;
        end
    end

    // Scoreboard
    typedef struct packed {
        logic [2:0]  code;
        logic [39:0] pa;
        logic [63:0] fsr;
        logic [63:0] tag;
    } exp_t;
    exp_t  exp_q[$];
    string rq_q[$];
    logic [63:0] m_fsr = '0, m_tag = '0;

    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R13 unexpected response", 64'(resp_fault_code), 64'd0);
            else begin
                exp_t  e;
                string r;
                e = exp_q.pop_front();
                r = rq_q.pop_front();
                chk(resp_fault_code == e.code, {r, " fault code"}, 64'(resp_fault_code), 64'(e.code));
                if (e.code == 3'd0) chk(resp_paddr == e.pa, {r, " paddr"}, 64'(resp_paddr), 64'(e.pa));
                chk(fsr == e.fsr, {r, " R10 fsr"}, fsr, e.fsr);
                chk(tag_access == e.tag, {r, " R7 tag"}, tag_access, e.tag);
            end
        end
    end

    // Driver: expected values from the requirements
    task automatic xl(input logic [63:0] mode, input logic [63:0] va, input logic [2:0] code,
                      input logic [39:0] pa, input logic [8:0] ft, input string r);
        exp_t e;
        logic nucm;
        logic [15:0] ctx;
        logic [63:0] eva;
        nucm = mode[18:16] != 3'd0;
        ctx  = (nucm || !mode[4]) ? 16'd0 : mode[47:32];
        eva  = mode[3] ? {32'b0, va[31:0]} : va;
        if (code == 3'd1 || (code == 3'd2 && ft != 9'd0))
            m_fsr = {40'b0, (nucm ? 8'h04 : 8'h80), ft, 1'b0, (nucm ? 2'd2 : 2'd0), 2'b00, m_fsr[0], 1'b1};
        if (code == 3'd3 || code == 3'd4) m_tag = {eva[63:13], ctx[12:0]};
        e.code = code; e.pa = pa; e.fsr = m_fsr; e.tag = m_tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        rq_q.push_back(r);
        req_valid = 1'b1; req_vaddr = va; mode_word = mode;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    localparam logic [63:0] M_HYP  = 64'h1;
    localparam logic [63:0] M_RED  = 64'h2;
    localparam logic [63:0] M_USER = 64'h0000_0123_0000_0510;
    localparam logic [63:0] M_PRIV = M_USER | 64'h4;
    localparam logic [63:0] M_TL   = M_PRIV | 64'h0001_0000;
    localparam logic [63:0] M_REAL = 64'h0000_0123_0000_0504;
    localparam logic [63:0] M_AM   = M_PRIV | 64'h8;

    initial begin
        int lk0;
        e_va[0] = 64'h40_0000; e_ctx[0] = 16'h123; e_real[0] = 0; e_priv[0] = 0; e_pb[0] = 40'h12_3456_0000; e_pm[0] = 40'h1FFF;
        e_va[1] = 64'h80_0000; e_ctx[1] = 16'h123; e_real[1] = 0; e_priv[1] = 1; e_pb[1] = 40'h00_7770_0000; e_pm[1] = 40'h1FFF;
        e_va[2] = 64'hA0_0000; e_ctx[2] = 16'h0;   e_real[2] = 1; e_priv[2] = 0; e_pb[2] = 40'h01_0000_0000; e_pm[2] = 40'hFFFF;
        e_va[3] = 64'h40_0000; e_ctx[3] = 16'h0;   e_real[3] = 0; e_priv[3] = 0; e_pb[3] = 40'h05_0000_0000; e_pm[3] = 40'h1FFF;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R13 reset ready", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R13 reset resp", 64'(resp_valid), 64'd0);
        chk(fsr == 64'd0 && tag_access == 64'd0, "R13 reset regs", fsr | tag_access, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        lk0 = lkups;
        xl(M_HYP, 64'hABCD_EF12_3456_7891, 3'd0, 40'h12_3456_7891, 9'd0, "R2 hypervisor bypass");
        xl(M_RED, 64'h0000_00FF_0000_1000, 3'd0, 40'hFF_0000_1000, 9'd0, "R2 reset bypass");
        chk(lkups == lk0, "R2 no lookup", 64'(lkups), 64'(lk0));

        xl(M_USER, 64'h40_0002, 3'd1, 40'd0, 9'h010, "R3 misaligned");
        xl(M_TL,   64'h40_0001, 3'd1, 40'd0, 9'h010, "R1 R10 nucleus misaligned overflow");
        xl(M_PRIV, 64'h0000_8000_0000_0000, 3'd2, 40'd0, 9'h040, "R5 hole low edge");
        xl(M_PRIV, 64'hFFFF_7FFF_FFFF_FFFC, 3'd2, 40'd0, 9'h040, "R5 hole high edge");
        xl(M_PRIV, 64'hFFFF_8000_0000_0000, 3'd4, 40'd0, 9'd0, "R5 above hole fast miss");

        lk0 = lkups;
        xl(M_USER, 64'h40_1234, 3'd0, 40'h12_3456_1234, 9'd0, "R9 hit");
        xl(M_USER, 64'h40_1ABC, 3'd0, 40'h12_3456_1ABC, 9'd0, "R11 cached hit");
        chk(lkups == lk0 + 1, "R11 no second lookup", 64'(lkups), 64'(lk0 + 1));
        xl(M_PRIV, 64'h40_1ABC, 3'd0, 40'h12_3456_1ABC, 9'd0, "R11 mode change");
        chk(lkups == lk0 + 2, "R11 mode change lookup", 64'(lkups), 64'(lk0 + 2));

        xl(M_USER, 64'h80_0040, 3'd2, 40'd0, 9'h001, "R8 privilege violation");
        xl(M_PRIV, 64'h80_0040, 3'd0, 40'h00_7770_0040, 9'd0, "R8 privileged ok");
        xl(M_PRIV, 64'h90_0044, 3'd4, 40'd0, 9'd0, "R6 R7 fast miss");
        xl(M_TL,   64'h40_0100, 3'd0, 40'h05_0000_0100, 9'd0, "R1 nucleus context hit");
        xl(M_TL,   64'h90_0044, 3'd4, 40'd0, 9'd0, "R1 nucleus miss tag");
        xl(M_REAL, 64'hA0_F00C, 3'd0, 40'h01_0000_F00C, 9'd0, "R6 R9 real hit large page");
        xl(M_REAL, 64'h40_0000, 3'd3, 40'd0, 9'd0, "R6 real miss");
        xl(M_AM, 64'hFFFF_FFFF_0040_0010, 3'd0, 40'h12_3456_0010, 9'd0, "R4 masked");
        xl(M_AM, 64'h0000_8000_0040_0010, 3'd0, 40'h12_3456_0010, 9'd0, "R4 masked no hole");

        xl(M_USER, 64'h40_1000, 3'd0, 40'h12_3456_1000, 9'd0, "R11 refill");
        e_pb[0] = 40'h22_0000_0000;
        xl(M_USER, 64'h40_1008, 3'd0, 40'h12_3456_1008, 9'd0, "R11 stale from cache");
        lk0 = lkups;
        @(negedge clk) tlb_change = 1'b1;
        @(negedge clk) tlb_change = 1'b0;
        xl(M_USER, 64'h40_1008, 3'd0, 40'h22_0000_1008, 9'd0, "R12 invalidated");
        chk(lkups == lk0 + 1, "R12 lookup after change", 64'(lkups), 64'(lk0 + 1));

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R13 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule